// File: doc/BRIEF.md
# Hamming weight threshold comparator

This combinational block reports whether an N-bit vector holds at least K ones. It never forms the full weight and never runs a magnitude comparison. Instead it loads the complement value 2^Q − K into one side of a Q-bit addition and keeps only that addition's carry-out. The carry rises exactly when the count of ones pushes the sum to 2^Q or higher. Seen as signed arithmetic, this is the same as starting from −K and asking whether the result is non-negative.

The low N−1 vector bits are summed into a Q-bit partial count. The top bit, index N−1, is not summed with them; it enters the final row as its carry-in. That final row computes only carries and has no sum logic.

By default the threshold comes from an input port and can be changed on the fly. Setting a parameter builds a fixed-threshold variant instead. In that variant each stage of the final row collapses to a single gate: an AND where the preset bit is 0 and an OR where it is 1. In the fixed variant the threshold port is ignored. Q must satisfy N ≤ 2^Q.

Top module: `hw_thresh_cmp`

## Requirements
- R1: With FIXED_EN=0 and thresh_in between 1 and 2^Q−1, ge_out is 1 exactly when the number of ones in vec_in is at least thresh_in (unsigned).
- R2: With FIXED_EN=0, thresh_in equal to 0 gives ge_out = 1 for every vec_in.
- R3: With FIXED_EN=0 and vec_in all zeros, ge_out is 1 only when thresh_in is 0.
- R4: Every bit position counts equally, including bit N−1 (fed as the carry-in). A vector with exactly one bit set gives ge_out = 1 exactly when thresh_in ≤ 1.
- R5: With FIXED_EN=1, ge_out is 1 exactly when the number of ones in vec_in is at least FIXED_K, and thresh_in has no effect on ge_out.
- R6: At the boundary, ge_out is 1 when the weight equals thresh_in and 0 when the weight equals thresh_in − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vec_in | input | N | Vector whose ones are counted |
| thresh_in | input | Q | Unsigned threshold K (ignored when FIXED_EN=1) |
| ge_out | output | 1 | 1 when the weight of vec_in is at least the threshold |

## Verification
Two things can decide the result in the same evaluation: the carry-in path that carries bit N−1, and the zero-threshold override. Both act when bit N−1 is set and thresh_in is 0, and also when the vector weight lands exactly on the threshold. The bench sweeps every vector of the 15-bit configuration against all 16 thresholds, so every such coincidence occurs. Each output is judged against a weight computed arithmetically in the bench. A second instance, built with a fixed threshold, is checked in the same sweep while its threshold port keeps changing.

// File: rtl/hw_thresh_cmp.sv
module hw_thresh_cmp #(
  parameter int N        = 15,
  parameter int Q        = 4,
  parameter bit FIXED_EN = 1'b0,
  parameter int FIXED_K  = 9
) (
  input  logic [N-1:0] vec_in,
  input  logic [Q-1:0] thresh_in,
  output logic         ge_out
);
  localparam logic [Q:0]   FULL_SCALE = (Q+1)'(1) << Q;
  localparam logic [Q:0]   FIX_WIDE   = FULL_SCALE - (Q+1)'(FIXED_K);
  localparam logic [Q-1:0] FIX_PRESET = FIX_WIDE[Q-1:0];
  localparam bit           FIX_ZERO   = (FIXED_K == 0);

  logic [Q-1:0] low_count;
  logic [Q-1:0] preset;
  logic [Q:0]   carry;
  logic         zero_k;
  wire          unused_thr = ^thresh_in;

  always_comb begin
    low_count = '0;
    for (int i = 0; i < N-1; i++)
      low_count = low_count + Q'(vec_in[i]);
  end

  assign carry[0] = vec_in[N-1];

  generate
    if (FIXED_EN) begin : g_fixed
      assign preset = FIX_PRESET;
      assign zero_k = FIX_ZERO;
      for (genvar i = 0; i < Q; i++) begin : g_stage
        if (FIX_PRESET[i]) begin : g_or
          assign carry[i+1] = low_count[i] | carry[i];
        end else begin : g_and
          assign carry[i+1] = low_count[i] & carry[i];
        end
      end
    end else begin : g_adj
      assign preset = ~thresh_in + Q'(1);
      assign zero_k = (thresh_in == '0);
      for (genvar i = 0; i < Q; i++) begin : g_stage
        assign carry[i+1] = (low_count[i] & preset[i]) |
                            ((low_count[i] ^ preset[i]) & carry[i]);
      end
    end
  endgenerate

  assign ge_out = carry[Q] | zero_k;
endmodule

// File: rtl/hw_thresh_cmp_chk.sv
module hw_thresh_cmp_chk #(
  parameter int N        = 15,
  parameter int Q        = 4,
  parameter bit FIXED_EN = 1'b0,
  parameter int FIXED_K  = 9
) (
  input logic [N-1:0] vec_in,
  input logic [Q-1:0] thresh_in,
  input logic         ge_out,
  input logic [Q-1:0] low_count
);
  int weight;
  int low_weight;
  always_comb begin
    weight     = $countones(vec_in);
    low_weight = $countones(vec_in[N-2:0]);
    assert_partial_count_R1: assert (int'(low_count) == low_weight);
    if (FIXED_EN) begin
      assert_fixed_match_R5: assert (ge_out == (weight >= FIXED_K));
    end else begin
      assert_ge_match_R1: assert (ge_out == (weight >= int'(thresh_in)));
      if (thresh_in == '0)
        assert_zero_thresh_R2: assert (ge_out);
      if (vec_in == '0)
        assert_empty_vec_R3: assert (ge_out == (thresh_in == '0));
      if ($onehot(vec_in))
        assert_single_bit_R4: assert (ge_out == (thresh_in <= Q'(1)));
    end
  end
endmodule

bind hw_thresh_cmp hw_thresh_cmp_chk #(
  .N(N), .Q(Q), .FIXED_EN(FIXED_EN), .FIXED_K(FIXED_K)
) u_chk (
  .vec_in(vec_in), .thresh_in(thresh_in), .ge_out(ge_out), .low_count(low_count)
);

// File: tb/hw_thresh_cmp_bench.sv
`timescale 1ns/10ps
module hw_thresh_cmp_bench;
  localparam int N  = 15;
  localparam int Q  = 4;
  localparam int FK = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] vec;
  logic [Q-1:0] thr;
  logic ge, ge_fix;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hw_thresh_cmp #(.N(N), .Q(Q)) u_hw_thresh_cmp (
    .vec_in(vec), .thresh_in(thr), .ge_out(ge));
  hw_thresh_cmp #(.N(N), .Q(Q), .FIXED_EN(1'b1), .FIXED_K(FK)) u_hw_thresh_cmp_fixed (
    .vec_in(vec), .thresh_in(thr), .ge_out(ge_fix));

  task automatic judge(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s vec=%h thr=%0d actual=%b expected=%b", tag, vec, thr, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec = '0; thr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    judge("R2 reset", ge, 1'b1);
    #0.25;
    for (int v = 0; v < (1 << N); v++) begin
      for (int t = 0; t < (1 << Q); t++) begin
        int w;
        string tag;
        vec = N'(v);
        thr = Q'(t);
        w = $countones(vec);
        #0.5;
        if (t == 0) tag = "R2";
        else if (v == 0) tag = "R3";
        else if (w == 1) tag = "R4";
        else if (w == t || w == t - 1) tag = "R6";
        else tag = "R1";
        judge(tag, ge, w >= t);
        judge("R5", ge_fix, w >= FK);
        #0.5;
      end
    end
    vec = N'(1) << (N-1); thr = Q'(1); #0.5;
    judge("R4 top bit", ge, 1'b1);
    thr = Q'(2); #0.5;
    judge("R4 top bit", ge, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule